// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a small programmable logic array. It holds a row of output macrocells. Each cell receives a group of already-evaluated product terms from the array and turns them into three things: the value it drives onto its pin, the tristate enable for that pin, and a feedback bit that goes back into the array. A shared clock and a shared active-low output-enable pin serve the registered cells. A synchronous preload path lets a test sequence force any register state, including states the logic could never reach on its own.

Two bank-wide configuration bits select one of three operating modes: registered, complex and simple. A fourth encoding is reserved. The mode sets how each cell uses its terms, either as data or with the lowest term acting as an enable. It also sets where the feedback comes from: the register, the cell's own pin, a neighbouring pin, or one of two auxiliary inputs that share the outer feedback slots. Two per-cell bits select output polarity and the cell's role. Every register is cleared by reset. Because the pin shows the inverse of the register, a registered pin comes out high after reset.

Top module: `pldmc_bank`

## Requirements
- R1: The mode is decoded from {cfg_nosync, cfg_wide}. 2'b01 is registered, 2'b11 is complex, 2'b10 is simple and 2'b00 is reserved. The decoding applies to every cell.
- R2: In registered mode, a cell with cfg_alt=0 is a registered cell. On each clock its register takes the sum of all its terms, adjusted for polarity. Its pin drives the inverse of the register, its enable is the inverse of oe_pin_n, and its feedback is the inverse of the register.
- R3: In registered mode, a cell with cfg_alt=1 is combinational. Term bit 0 of the cell is its enable and bits 7..1 are ORed into the data. Its feedback is its pad value (R7).
- R4: In complex mode, every cell behaves as in R3. Feedback slot 0 carries aux_a and slot 7 carries aux_b, in place of those cells' own pad values.
- R5: In simple mode, all eight terms are ORed and the pin is always enabled. The exception is cfg_alt=1 on a cell other than the centre cells 3 and 4: that turns the driver off, and centre cells ignore cfg_alt. Slot 0 carries aux_a and slot 7 carries aux_b. Slots 1 to 3 carry the pad values of cells 0 to 2, and slots 4 to 6 carry the pad values of cells 5 to 7. The pads of cells 3 and 4 are not fed back.
- R6: Polarity applies in every mode. With cfg_hi_act=1 the driven level equals the term sum; with cfg_hi_act=0 it equals the inverted sum.
- R7: A cell's pad value is its driven level when it is enabled, and its pad_in bit otherwise. pin_out reads 0 for any disabled cell.
- R8: While reset is applied, every register is 0. Every enabled registered pin therefore reads 1, whatever its polarity bit.
- R9: When pre_en is high on a clock edge, each register loads its pre_val bit in any mode. This takes priority over the normal D input.
- R10: In the reserved mode, every driver is off and every feedback bit is 0.
- R11: A register whose cell is not registered, including in any mode other than registered, holds its value unless preload is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_nosync | input | 1 | Bank mode bit, high for complex or simple |
| cfg_wide | input | 1 | Bank mode bit, selects the mode together with cfg_nosync |
| cfg_hi_act | input | 8 | Per-cell polarity, 1 = active high |
| cfg_alt | input | 8 | Per-cell role bit |
| pt_in | input | 64 | Product terms, cell c at bits [8c+7:8c], bit 8c is the enable term |
| oe_pin_n | input | 1 | Shared active-low enable for registered cells |
| aux_a | input | 1 | Auxiliary input on feedback slot 0 |
| aux_b | input | 1 | Auxiliary input on feedback slot 7 |
| pre_en | input | 1 | Synchronous preload strobe |
| pre_val | input | 8 | Preload value per register |
| pad_in | input | 8 | Level seen on each pin when its driver is off |
| pin_out | output | 8 | Driven pin level (0 when disabled) |
| pin_oe | output | 8 | Per-pin driver enable |
| pin_fb | output | 8 | Feedback bits to the array |

## Verification
The assertions assume three things about the inputs. Configuration, terms and pads change only away from the rising clock edge. Preload is not strobed while reset, or the two-cycle release that follows it, is in progress. A preload is checked only if the registered configuration is still present on the next cycle. The stimulus keeps within these assumptions. Every input is updated on the falling edge. The bench holds the terms at zero with active-low polarity, and preload idle, for several cycles after reset is released. It samples outputs just after each update, before the next rising edge, so preload and register effects are observed one vector later.

// File: rtl/pldmc_pkg.sv
package pldmc_pkg;

  typedef enum logic [1:0] {
    BANK_RSVD = 2'b00,
    BANK_REG  = 2'b01,
    BANK_SMP  = 2'b10,
    BANK_CPX  = 2'b11
  } bank_mode_e;

  // {nosync, wide} maps straight onto the enum encoding above (R1)
  function automatic bank_mode_e decode_mode(input logic nosync, input logic wide);
    bank_mode_e m;
    case ({nosync, wide})
      2'b01:   m = BANK_REG;
      2'b11:   m = BANK_CPX;
      2'b10:   m = BANK_SMP;
      default: m = BANK_RSVD;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pldmc_rst_sync.sv
module pldmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];

endmodule

// File: rtl/pldmc_mode_dec.sv
module pldmc_mode_dec
  import pldmc_pkg::*;
#(
  parameter int NCELL = 8
) (
  input  logic             cfg_nosync,
  input  logic             cfg_wide,
  input  logic [NCELL-1:0] cfg_alt,
  output bank_mode_e       mode,
  output logic [NCELL-1:0] reg_mask
);

  always_comb begin
    mode = decode_mode(cfg_nosync, cfg_wide);
  end

  // a cell is a clocked output only in registered mode with its role bit low (R2, R11)
  for (genvar c = 0; c < NCELL; c++) begin : g_mask
    assign reg_mask[c] = (mode == BANK_REG) && !cfg_alt[c];
  end

endmodule

// File: rtl/pldmc_cell.sv
module pldmc_cell
  import pldmc_pkg::*;
#(
  parameter int NPT    = 8,
  parameter bit CENTRE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  bank_mode_e     mode,
  input  logic           is_reg,
  input  logic           alt,
  input  logic           hi_act,
  input  logic [NPT-1:0] terms,
  input  logic           oe_pin_n,
  input  logic           pre_en,
  input  logic           pre_val,
  input  logic           pad_in,
  output logic           drv,
  output logic           drv_en,
  output logic           pad_val,
  output logic           reg_fb
);

  logic sum_all;
  logic sum_data;
  logic lvl_all;
  logic lvl_data;
  logic en_c;
  logic dat_c;
  logic q_r;
  logic q_nxt;
  logic q_en;

  always_comb begin
    sum_all  = |terms;
    sum_data = |terms[NPT-1:1];
    lvl_all  = hi_act ? sum_all  : !sum_all;
    lvl_data = hi_act ? sum_data : !sum_data;
  end

  // driver enable and level per mode
  always_comb begin
    en_c  = 1'b0;
    dat_c = 1'b0;
    case (mode)
      BANK_REG: begin
        if (is_reg) begin
          en_c  = !oe_pin_n;
          dat_c = !q_r;
        end else begin
          en_c  = terms[0];
          dat_c = lvl_data;
        end
      end
      BANK_CPX: begin
        en_c  = terms[0];
        dat_c = lvl_data;
      end
      BANK_SMP: begin
        en_c  = !(alt && !CENTRE);
        dat_c = lvl_all;
      end
      default: begin
        en_c  = 1'b0;
        dat_c = 1'b0;
      end
    endcase
  end

  assign drv     = en_c & dat_c;
  assign drv_en  = en_c;
  assign pad_val = en_c ? dat_c : pad_in;

  // register next state: preload wins over D; D is stored inverted so pin = ~q
  always_comb begin
    q_en  = pre_en | is_reg;
    q_nxt = pre_en ? pre_val : !lvl_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= 1'b0;
    else if (q_en) q_r <= q_nxt;
  end

  assign reg_fb = !q_r;

endmodule

// File: rtl/pldmc_fb_route.sv
module pldmc_fb_route
  import pldmc_pkg::*;
#(
  parameter int NCELL = 8
) (
  input  bank_mode_e       mode,
  input  logic [NCELL-1:0] reg_mask,
  input  logic [NCELL-1:0] pad_val,
  input  logic [NCELL-1:0] reg_fb,
  input  logic             aux_a,
  input  logic             aux_b,
  output logic [NCELL-1:0] fb
);

  localparam int HALF = NCELL / 2;

  for (genvar s = 0; s < NCELL; s++) begin : g_slot
    localparam bit IS_LO_EDGE = (s == 0);
    localparam bit IS_HI_EDGE = (s == NCELL - 1);
    // neighbour whose pad feeds this slot in simple mode: outward from the centre
    localparam int NB = IS_LO_EDGE ? 0 :
                        IS_HI_EDGE ? NCELL - 1 :
                        (s < HALF) ? s - 1 : s + 1;

    logic edge_aux;
    if (IS_LO_EDGE)      begin : g_lo assign edge_aux = aux_a; end
    else if (IS_HI_EDGE) begin : g_hi assign edge_aux = aux_b; end
    else                 begin : g_mid assign edge_aux = 1'b0; end

    always_comb begin
      case (mode)
        BANK_REG: fb[s] = reg_mask[s] ? reg_fb[s] : pad_val[s];
        BANK_CPX: fb[s] = (IS_LO_EDGE || IS_HI_EDGE) ? edge_aux : pad_val[s];
        BANK_SMP: fb[s] = (IS_LO_EDGE || IS_HI_EDGE) ? edge_aux : pad_val[NB];
        default:  fb[s] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pldmc_bank.sv
module pldmc_bank
  import pldmc_pkg::*;
#(
  parameter int NCELL = 8,
  parameter int NPT   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_nosync,
  input  logic                 cfg_wide,
  input  logic [NCELL-1:0]     cfg_hi_act,
  input  logic [NCELL-1:0]     cfg_alt,
  input  logic [NCELL*NPT-1:0] pt_in,
  input  logic                 oe_pin_n,
  input  logic                 aux_a,
  input  logic                 aux_b,
  input  logic                 pre_en,
  input  logic [NCELL-1:0]     pre_val,
  input  logic [NCELL-1:0]     pad_in,
  output logic [NCELL-1:0]     pin_out,
  output logic [NCELL-1:0]     pin_oe,
  output logic [NCELL-1:0]     pin_fb
);

  localparam int CENTRE_LO = NCELL / 2 - 1;
  localparam int CENTRE_HI = NCELL / 2;

  logic             rst_int_n;
  bank_mode_e       mode;
  logic [NCELL-1:0] reg_mask;
  logic [NCELL-1:0] pad_val;
  logic [NCELL-1:0] reg_fb;

  pldmc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  pldmc_mode_dec #(.NCELL(NCELL)) u_dec (
    .cfg_nosync (cfg_nosync),
    .cfg_wide   (cfg_wide),
    .cfg_alt    (cfg_alt),
    .mode       (mode),
    .reg_mask   (reg_mask)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    pldmc_cell #(
      .NPT    (NPT),
      .CENTRE ((c == CENTRE_LO) || (c == CENTRE_HI))
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .mode     (mode),
      .is_reg   (reg_mask[c]),
      .alt      (cfg_alt[c]),
      .hi_act   (cfg_hi_act[c]),
      .terms    (pt_in[c*NPT +: NPT]),
      .oe_pin_n (oe_pin_n),
      .pre_en   (pre_en),
      .pre_val  (pre_val[c]),
      .pad_in   (pad_in[c]),
      .drv      (pin_out[c]),
      .drv_en   (pin_oe[c]),
      .pad_val  (pad_val[c]),
      .reg_fb   (reg_fb[c])
    );
  end

  pldmc_fb_route #(.NCELL(NCELL)) u_route (
    .mode     (mode),
    .reg_mask (reg_mask),
    .pad_val  (pad_val),
    .reg_fb   (reg_fb),
    .aux_a    (aux_a),
    .aux_b    (aux_b),
    .fb       (pin_fb)
  );

endmodule

// File: rtl/pldmc_bank_chk.sv
module pldmc_bank_chk #(
  parameter int NCELL = 8,
  parameter int NPT   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_nosync,
  input logic                 cfg_wide,
  input logic [NCELL-1:0]     cfg_alt,
  input logic [NCELL*NPT-1:0] pt_in,
  input logic                 oe_pin_n,
  input logic                 aux_a,
  input logic                 aux_b,
  input logic                 pre_en,
  input logic [NCELL-1:0]     pre_val,
  input logic [NCELL-1:0]     pin_out,
  input logic [NCELL-1:0]     pin_oe,
  input logic [NCELL-1:0]     pin_fb
);

  localparam int CLO = NCELL / 2 - 1;
  localparam int CHI = NCELL / 2;

  logic m_reg, m_cpx, m_smp, m_rsv;
  assign m_reg = !cfg_nosync &&  cfg_wide;
  assign m_cpx =  cfg_nosync &&  cfg_wide;
  assign m_smp =  cfg_nosync && !cfg_wide;
  assign m_rsv = !cfg_nosync && !cfg_wide;

  a_r10_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsv |-> (pin_oe == '0 && pin_fb == '0));

  a_r5_centre_driven: assert property (@(posedge clk) disable iff (!rst_n)
    m_smp |-> (pin_oe[CLO] && pin_oe[CHI]));

  a_r4_outer_aux: assert property (@(posedge clk) disable iff (!rst_n)
    m_cpx |-> (pin_fb[0] == aux_a && pin_fb[NCELL-1] == aux_b));

  a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  for (genvar i = 0; i < NCELL; i++) begin : g_cell_chk
    a_r2_shared_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (m_reg && !cfg_alt[i]) |-> (pin_oe[i] == !oe_pin_n));

    a_r3_term_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (m_reg && cfg_alt[i]) |-> (pin_oe[i] == pt_in[i*NPT]));

    a_r9_preload_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_en && m_reg && !cfg_alt[i]) |=>
        (!(m_reg && !cfg_alt[i]) || pin_fb[i] == !$past(pre_val[i])));
  end

endmodule

bind pldmc_bank pldmc_bank_chk #(.NCELL(NCELL), .NPT(NPT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_nosync (cfg_nosync),
  .cfg_wide   (cfg_wide),
  .cfg_alt    (cfg_alt),
  .pt_in      (pt_in),
  .oe_pin_n   (oe_pin_n),
  .aux_a      (aux_a),
  .aux_b      (aux_b),
  .pre_en     (pre_en),
  .pre_val    (pre_val),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .pin_fb     (pin_fb)
);

// File: tb/pldmc_bank_test.sv
`timescale 1ns/1ps
module pldmc_bank_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_nosync, cfg_wide;
  logic [7:0]  cfg_hi_act, cfg_alt;
  logic [63:0] pt_in;
  logic        oe_pin_n, aux_a, aux_b, pre_en;
  logic [7:0]  pre_val, pad_in;
  logic [7:0]  pin_out, pin_oe, pin_fb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] m_q;
  logic [7:0] e_oe, e_out, e_fb, e_pad;

  always #2 clk = ~clk;

  pldmc_bank uut (
    .clk(clk), .rst_n(rst_n), .cfg_nosync(cfg_nosync), .cfg_wide(cfg_wide),
    .cfg_hi_act(cfg_hi_act), .cfg_alt(cfg_alt), .pt_in(pt_in),
    .oe_pin_n(oe_pin_n), .aux_a(aux_a), .aux_b(aux_b), .pre_en(pre_en),
    .pre_val(pre_val), .pad_in(pad_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_fb(pin_fb)
  );

  // expected outputs from the requirements, using the bench's own register image
  task automatic predict();
    logic [1:0] m;
    m = {cfg_nosync, cfg_wide};
    for (int c = 0; c < 8; c++) begin
      logic [7:0] t;
      logic s8, s7, en, d;
      t  = pt_in[c*8 +: 8];
      s8 = |t;
      s7 = |t[7:1];
      en = 1'b0; d = 1'b0;
      if (m == 2'b01 && !cfg_alt[c]) begin en = !oe_pin_n; d = !m_q[c]; end
      else if (m == 2'b01 || m == 2'b11) begin en = t[0]; d = cfg_hi_act[c] ? s7 : !s7; end
      else if (m == 2'b10) begin
        en = !(cfg_alt[c] && c != 3 && c != 4);
        d  = cfg_hi_act[c] ? s8 : !s8;
      end
      e_oe[c]  = en;
      e_out[c] = en & d;
      e_pad[c] = en ? d : pad_in[c];
    end
    for (int s = 0; s < 8; s++) begin
      case (m)
        2'b01: e_fb[s] = !cfg_alt[s] ? !m_q[s] : e_pad[s];
        2'b11: e_fb[s] = (s == 0) ? aux_a : (s == 7) ? aux_b : e_pad[s];
        2'b10: e_fb[s] = (s == 0) ? aux_a : (s == 7) ? aux_b :
                         (s < 4) ? e_pad[s-1] : e_pad[s+1];
        default: e_fb[s] = 1'b0;
      endcase
    end
  endtask

  task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check(input string tag);
    #1;
    predict();
    cmp(tag, "pin_out", pin_out, e_out);
    cmp(tag, "pin_oe",  pin_oe,  e_oe);
    cmp(tag, "pin_fb",  pin_fb,  e_fb);
  endtask

  task automatic tick();
    @(posedge clk);
    for (int c = 0; c < 8; c++) begin
      if (pre_en) m_q[c] = pre_val[c];
      else if (!cfg_nosync && cfg_wide && !cfg_alt[c])
        m_q[c] = cfg_hi_act[c] ? !(|pt_in[c*8 +: 8]) : |pt_in[c*8 +: 8];
    end
  endtask

  task automatic run(input string tag);
    check(tag);
    tick();
  endtask

  task automatic set_mode(input logic [1:0] m);
    {cfg_nosync, cfg_wide} = m;
  endtask

  function automatic logic [63:0] sparse();
    return {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
  endfunction

  function automatic string mode_tag();
    case ({cfg_nosync, cfg_wide})
      2'b01:   return "R2";
      2'b11:   return "R4";
      2'b10:   return "R5";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4271));
    rst_n = 1'b0; m_q = '0;
    set_mode(2'b01); cfg_alt = '0; cfg_hi_act = 8'hA5; pt_in = '1;
    oe_pin_n = 1'b0; aux_a = 1'b0; aux_b = 1'b0; pre_en = 1'b0; pre_val = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    check("R8");                                   // registered pins high in reset, mixed polarity
    @(negedge clk); cfg_hi_act = 8'h5A; check("R8");
    @(negedge clk); cfg_hi_act = '0; pt_in = '0; rst_n = 1'b1;
    repeat (4) @(posedge clk);                      // internal release; D stays 0

    // R1: same terms through all four encodings
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); set_mode(k[1:0]); pt_in = 64'h0F01_00FE_3300_8001;
      cfg_hi_act = 8'h96; cfg_alt = 8'h18; pad_in = 8'hC3; aux_a = 1'b1; aux_b = 1'b0;
      run("R1");
    end
    // R2: registered cells follow D one clock later
    @(negedge clk); set_mode(2'b01); cfg_alt = '0; cfg_hi_act = 8'hF0; pt_in = 64'h00FF_0100_0000_FF02; run("R2");
    @(negedge clk); pt_in = '0; run("R2");
    @(negedge clk); oe_pin_n = 1'b1; run("R2");
    @(negedge clk); oe_pin_n = 1'b0; run("R2");
    // R3: combinational cells in registered mode
    @(negedge clk); cfg_alt = '1; pt_in = 64'h0301_0200_FF81_8001; pad_in = 8'h55; run("R3");
    // R4: outer feedback slots carry aux inputs
    @(negedge clk); set_mode(2'b11); aux_a = 1'b0; aux_b = 1'b1; pt_in = '1; run("R4");
    @(negedge clk); aux_a = 1'b1; aux_b = 1'b0; run("R4");
    // R5: simple mode with every role bit set, centre cells stay driven
    @(negedge clk); set_mode(2'b10); cfg_alt = '1; pad_in = 8'hA6; run("R5");
    @(negedge clk); cfg_alt = '0; pt_in = 64'h0000_0100_0000_0080; cfg_hi_act = 8'h0F; run("R5");
    // R6: polarity flip with identical terms
    @(negedge clk); set_mode(2'b11); pt_in = 64'hFF03_0001_0203_0507; cfg_hi_act = '1; run("R6");
    @(negedge clk); cfg_hi_act = '0; run("R6");
    // R7: disabled pins read pad_in on feedback and drive 0
    @(negedge clk); pt_in = 64'h00FF_01FE_00FF_01FE; pad_in = 8'hF0; run("R7");
    @(negedge clk); pad_in = 8'h0F; run("R7");
    // R9: preload overrides D, including an unreachable pattern
    @(negedge clk); set_mode(2'b01); cfg_alt = '0; pt_in = '1; cfg_hi_act = '1;
    pre_en = 1'b1; pre_val = 8'h3C; run("R9");
    @(negedge clk); pre_en = 1'b0; pt_in = '0; cfg_hi_act = '0; run("R9");
    // R11: preload, leave registered mode for a while, return and read held state
    @(negedge clk); pre_en = 1'b1; pre_val = 8'h5A; run("R11");
    @(negedge clk); pre_en = 1'b0; set_mode(2'b10); pt_in = '1; cfg_hi_act = '1; run("R11");
    @(negedge clk); set_mode(2'b11); run("R11");
    @(negedge clk); set_mode(2'b01); cfg_alt = 8'hFF; run("R11");
    @(negedge clk); cfg_alt = '0; run("R11");
    // R10: reserved mode is quiet, preload still loads
    @(negedge clk); set_mode(2'b00); pre_en = 1'b1; pre_val = 8'h81; run("R10");
    @(negedge clk); pre_en = 1'b0; set_mode(2'b01); pt_in = '0; cfg_hi_act = '0; run("R10");

    // constrained random
    for (int v = 0; v < 800; v++) begin
      @(negedge clk);
      set_mode(2'($urandom_range(3, 0)));
      cfg_hi_act = 8'($urandom); cfg_alt = 8'($urandom);
      pt_in = sparse(); pad_in = 8'($urandom);
      oe_pin_n = ($urandom_range(3, 0) == 0);
      aux_a = 1'($urandom); aux_b = 1'($urandom);
      pre_en = ($urandom_range(7, 0) == 0); pre_val = 8'($urandom);
      run(mode_tag());
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule